// File: doc/BRIEF.md
# I2C Master Command and Receive Queue Front End

This block sits between software and the bit-level engine of an I2C master. Software pushes 11-bit command words, one per byte to be sent or fetched, into a command queue. The bus engine takes commands from the head of that queue through a valid/ready handshake and, for every completed read, pushes the received byte into a receive queue, which software drains through a read strobe.

Both queues report their fill level. Two programmable thresholds turn those levels into a "transmit side wants more commands" flag and a "receive side holds data" flag, suitable for raising interrupts. Writing to a full command queue, pushing into a full receive queue and reading an empty receive queue each produce a one-cycle error pulse. An abort from the bus engine empties both queues in one cycle.

Top module: `i2cq_front`

## Requirements
- R1: A command word is decoded at write time: bit 8 set means a read request, with eng_cmd_is_read = 1 and eng_cmd_data = 0 whatever bits 7:0 hold; bit 8 clear means a write with eng_cmd_data = bits 7:0; bit 9 set drives eng_cmd_stop = 1; bit 10 is ignored.
- R2: tx_level and rx_level give the number of valid entries in each queue, are 0 after reset, change by at most one per cycle, and a simultaneous accepted push and pop leaves the level unchanged.
- R3: Both queues are first-in first-out: commands reach the bus engine, and bytes reach software, in the order they were written.
- R4: rx_has_data is 1 exactly when rx_level > rx_thresh; with rx_thresh = 0 it rises in the same cycle that rx_level becomes 1. It is 0 after reset.
- R5: tx_need_data is 1 exactly when tx_level <= tx_thresh. It is 1 after reset.
- R6: When eng_abort is 1 at a clock edge, both levels become 0 at that edge and every push, pop and read presented in the same cycle is discarded without an error pulse.
- R7: cmd_wr_en while tx_level equals DEPTH drops the word, keeps the level, and pulses tx_over for one cycle after that edge.
- R8: eng_rx_valid while rx_level equals DEPTH drops the byte and pulses rx_over; rx_rd_en while rx_level is 0 pulses rx_under and leaves rx_rd_data unchanged.
- R9: An accepted rx_rd_en pops one byte, which appears on rx_rd_data bits 7:0 one cycle later with bits 10:8 reading 0.
- R10: eng_cmd_valid is 1 exactly when tx_level is nonzero; eng_cmd_ready while the command queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_en | input | 1 | Software writes a command word |
| cmd_wr_word | input | 11 | Command word: bit 9 stop, bit 8 read, bits 7:0 write byte |
| tx_thresh | input | LW | Command queue threshold |
| rx_thresh | input | LW | Receive queue threshold |
| rx_rd_en | input | 1 | Software pops one received byte |
| rx_rd_data | output | 11 | Popped byte in bits 7:0, upper bits 0 |
| eng_cmd_valid | output | 1 | A command is waiting for the bus engine |
| eng_cmd_ready | input | 1 | Bus engine takes the head command |
| eng_cmd_is_read | output | 1 | Head command requests a read |
| eng_cmd_stop | output | 1 | Head command ends with a STOP |
| eng_cmd_data | output | 8 | Byte to transmit (0 for reads) |
| eng_rx_valid | input | 1 | Bus engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_abort | input | 1 | Transfer aborted, flush both queues |
| tx_level | output | LW | Entries in the command queue |
| rx_level | output | LW | Entries in the receive queue |
| tx_need_data | output | 1 | tx_level at or below tx_thresh |
| rx_has_data | output | 1 | rx_level above rx_thresh |
| tx_over | output | 1 | Pulse: command written into a full queue |
| rx_over | output | 1 | Pulse: byte pushed into a full queue |
| rx_under | output | 1 | Pulse: read from an empty queue |

LW is $clog2(DEPTH+1), 4 for the default depth of 8.

## Verification
The assertions watch, on every cycle, that levels stay within the depth and move by at most one, that an abort leaves both queues empty, that each illegal push or read produces its error pulse, that the head-valid signal tracks the command level, that read commands carry no data, and that both threshold flags agree with the levels whenever the thresholds hold steady. Ordering through the queues, the exact decode of each command word, the dropping of words on overflow, and the value returned by each software read depend on the history of data written, so only the bench's scenarios, which compare the engine-side and software-side outputs against words and bytes it chose, can show them.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

  localparam int CMD_W    = 11;
  localparam int BYTE_W   = 8;
  localparam int RD_BIT   = 8;
  localparam int STOP_BIT = 9;

  // Decoded command as held in the command queue.
  typedef struct packed {
    logic              is_read;
    logic              stop;
    logic [BYTE_W-1:0] data;
  } eng_cmd_t;

  localparam int ENTRY_W = $bits(eng_cmd_t);

  // Read requests carry no payload; the byte field is forced to zero.
  function automatic eng_cmd_t decode_cmd(input logic [STOP_BIT:0] w);
    eng_cmd_t c;
    c.is_read = w[RD_BIT];
    c.stop    = w[STOP_BIT];
    c.data    = w[RD_BIT] ? '0 : w[BYTE_W-1:0];
    return c;
  endfunction

endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [LW-1:0]    count,
  output logic [LW-1:0]    count_nxt
);

  localparam logic [LW-1:0] FULL_CNT = LW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic             do_push;
  logic             do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + AW'(1);
  endfunction

  assign do_push = push && !flush && (count != FULL_CNT);
  assign do_pop  = pop  && !flush && (count != '0);

  // Storage without reset so it maps onto RAM resources.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
    end
  end

  always_comb begin
    if (flush) begin
      count_nxt = '0;
    end else begin
      unique case ({do_push, do_pop})
        2'b10:   count_nxt = count + LW'(1);
        2'b01:   count_nxt = count - LW'(1);
        default: count_nxt = count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_nxt;
  end

endmodule

// File: rtl/i2cq_thresh.sv
module i2cq_thresh #(
  parameter int LW    = 4,
  parameter bit ABOVE = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] level_nxt,
  input  logic [LW-1:0] thresh,
  output logic          flag
);

  logic hit;

  generate
    if (ABOVE) begin : g_above
      assign hit = level_nxt > thresh;
    end else begin : g_at_or_below
      assign hit = level_nxt <= thresh;
    end
  endgenerate

  // Registered so the flag moves in the same cycle as the level register.
  always_ff @(posedge clk) begin
    if (rst) flag <= !ABOVE;
    else     flag <= hit;
  end

endmodule

// File: rtl/i2cq_front.sv
module i2cq_front #(
  parameter int DEPTH = 8,
  localparam int LW    = $clog2(DEPTH + 1),
  localparam int CMD_W = i2cq_pkg::CMD_W,
  localparam int BW    = i2cq_pkg::BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr_en,
  input  logic [CMD_W-1:0] cmd_wr_word,
  input  logic [LW-1:0]    tx_thresh,
  input  logic [LW-1:0]    rx_thresh,
  input  logic             rx_rd_en,
  output logic [CMD_W-1:0] rx_rd_data,
  output logic             eng_cmd_valid,
  input  logic             eng_cmd_ready,
  output logic             eng_cmd_is_read,
  output logic             eng_cmd_stop,
  output logic [BW-1:0]    eng_cmd_data,
  input  logic             eng_rx_valid,
  input  logic [BW-1:0]    eng_rx_data,
  input  logic             eng_abort,
  output logic [LW-1:0]    tx_level,
  output logic [LW-1:0]    rx_level,
  output logic             tx_need_data,
  output logic             rx_has_data,
  output logic             tx_over,
  output logic             rx_over,
  output logic             rx_under
);

  import i2cq_pkg::*;

  localparam logic [LW-1:0] FULL_CNT = LW'(DEPTH);

  eng_cmd_t        wr_entry;
  eng_cmd_t        tx_head;
  logic [LW-1:0]   tx_level_nxt;
  logic [LW-1:0]   rx_level_nxt;
  logic [BW-1:0]   rx_head;
  logic            tx_full;
  logic            rx_full;
  logic            rx_empty;
  logic            rx_pop_ok;
  logic            cmd_bit10_unused;

  assign cmd_bit10_unused = cmd_wr_word[CMD_W-1];
  assign wr_entry         = decode_cmd(cmd_wr_word[STOP_BIT:0]);

  assign tx_full  = (tx_level == FULL_CNT);
  assign rx_full  = (rx_level == FULL_CNT);
  assign rx_empty = (rx_level == '0);

  i2cq_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_cmd_q (
    .clk       (clk),
    .rst       (rst),
    .flush     (eng_abort),
    .push      (cmd_wr_en),
    .wdata     (wr_entry),
    .pop       (eng_cmd_ready),
    .head      (tx_head),
    .count     (tx_level),
    .count_nxt (tx_level_nxt)
  );

  i2cq_fifo #(.WIDTH(BW), .DEPTH(DEPTH)) u_rx_q (
    .clk       (clk),
    .rst       (rst),
    .flush     (eng_abort),
    .push      (eng_rx_valid),
    .wdata     (eng_rx_data),
    .pop       (rx_rd_en),
    .head      (rx_head),
    .count     (rx_level),
    .count_nxt (rx_level_nxt)
  );

  i2cq_thresh #(.LW(LW), .ABOVE(1'b0)) u_tx_thr (
    .clk       (clk),
    .rst       (rst),
    .level_nxt (tx_level_nxt),
    .thresh    (tx_thresh),
    .flag      (tx_need_data)
  );

  i2cq_thresh #(.LW(LW), .ABOVE(1'b1)) u_rx_thr (
    .clk       (clk),
    .rst       (rst),
    .level_nxt (rx_level_nxt),
    .thresh    (rx_thresh),
    .flag      (rx_has_data)
  );

  // Bus engine view of the queue head.
  assign eng_cmd_valid   = (tx_level != '0);
  assign eng_cmd_is_read = tx_head.is_read;
  assign eng_cmd_stop    = tx_head.stop;
  assign eng_cmd_data    = tx_head.data;

  // Registered software read port.
  assign rx_pop_ok = rx_rd_en && !rx_empty && !eng_abort;

  always_ff @(posedge clk) begin
    if (rst)            rx_rd_data <= '0;
    else if (rx_pop_ok) rx_rd_data <= {{(CMD_W-BW){1'b0}}, rx_head};
  end

  // Error pulses, one cycle after the offending request.
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_over  <= 1'b0;
      rx_over  <= 1'b0;
      rx_under <= 1'b0;
    end else begin
      tx_over  <= cmd_wr_en    && tx_full  && !eng_abort;
      rx_over  <= eng_rx_valid && rx_full  && !eng_abort;
      rx_under <= rx_rd_en     && rx_empty && !eng_abort;
    end
  end

endmodule

// File: rtl/i2cq_front_chk.sv
module i2cq_front_chk #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_wr_en,
  input logic [10:0]   cmd_wr_word,
  input logic [LW-1:0] tx_thresh,
  input logic [LW-1:0] rx_thresh,
  input logic          rx_rd_en,
  input logic [10:0]   rx_rd_data,
  input logic          eng_cmd_valid,
  input logic          eng_cmd_ready,
  input logic          eng_cmd_is_read,
  input logic          eng_cmd_stop,
  input logic [7:0]    eng_cmd_data,
  input logic          eng_rx_valid,
  input logic [7:0]    eng_rx_data,
  input logic          eng_abort,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          tx_need_data,
  input logic          rx_has_data,
  input logic          tx_over,
  input logic          rx_over,
  input logic          rx_under
);

  localparam int D = DEPTH;

  p_level_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (int'(tx_level) <= D) && (int'(rx_level) <= D));

  p_level_step_r2: assert property (@(posedge clk) disable iff (rst)
    !eng_abort |=>
      (int'(tx_level) <= int'($past(tx_level)) + 1) &&
      (int'(tx_level) + 1 >= int'($past(tx_level))) &&
      (int'(rx_level) <= int'($past(rx_level)) + 1) &&
      (int'(rx_level) + 1 >= int'($past(rx_level))));

  p_abort_flush_r6: assert property (@(posedge clk) disable iff (rst)
    eng_abort |=> (tx_level == '0) && (rx_level == '0) && !tx_over && !rx_over && !rx_under);

  p_tx_over_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr_en && int'(tx_level) == D && !eng_abort) |=> tx_over);

  p_rx_over_r8: assert property (@(posedge clk) disable iff (rst)
    (eng_rx_valid && int'(rx_level) == D && !eng_abort) |=> rx_over);

  p_rx_under_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_rd_en && rx_level == '0 && !eng_abort) |=> (rx_under && $stable(rx_rd_data)));

  p_read_nodata_r1: assert property (@(posedge clk) disable iff (rst)
    (eng_cmd_valid && eng_cmd_is_read) |-> (eng_cmd_data == 8'h00));

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
    rx_rd_data[10:8] == 3'b000);

  p_valid_r10: assert property (@(posedge clk) disable iff (rst)
    eng_cmd_valid == (tx_level != '0));

  p_rx_flag_r4: assert property (@(posedge clk) disable iff (rst)
    $stable(rx_thresh) |-> (rx_has_data == (rx_level > rx_thresh)));

  p_tx_flag_r5: assert property (@(posedge clk) disable iff (rst)
    $stable(tx_thresh) |-> (tx_need_data == (tx_level <= tx_thresh)));

endmodule

bind i2cq_front i2cq_front_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_i2cq_front.sv
`timescale 1ns/1ps
module tb_i2cq_front;

  localparam int DEPTH = 8;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_wr_en = 1'b0;
  logic [10:0]   cmd_wr_word = '0;
  logic [LW-1:0] tx_thresh = LW'(DEPTH - 1);
  logic [LW-1:0] rx_thresh = '0;
  logic          rx_rd_en = 1'b0;
  logic [10:0]   rx_rd_data;
  logic          eng_cmd_valid;
  logic          eng_cmd_ready = 1'b0;
  logic          eng_cmd_is_read;
  logic          eng_cmd_stop;
  logic [7:0]    eng_cmd_data;
  logic          eng_rx_valid = 1'b0;
  logic [7:0]    eng_rx_data = '0;
  logic          eng_abort = 1'b0;
  logic [LW-1:0] tx_level;
  logic [LW-1:0] rx_level;
  logic          tx_need_data;
  logic          rx_has_data;
  logic          tx_over;
  logic          rx_over;
  logic          rx_under;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  i2cq_front #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .cmd_wr_en(cmd_wr_en), .cmd_wr_word(cmd_wr_word),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .rx_rd_en(rx_rd_en),
    .rx_rd_data(rx_rd_data), .eng_cmd_valid(eng_cmd_valid),
    .eng_cmd_ready(eng_cmd_ready), .eng_cmd_is_read(eng_cmd_is_read),
    .eng_cmd_stop(eng_cmd_stop), .eng_cmd_data(eng_cmd_data),
    .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
    .eng_abort(eng_abort), .tx_level(tx_level), .rx_level(rx_level),
    .tx_need_data(tx_need_data), .rx_has_data(rx_has_data),
    .tx_over(tx_over), .rx_over(rx_over), .rx_under(rx_under)
  );

  // Command word, expected read flag, stop flag and byte at the engine side.
  typedef struct packed {
    logic [10:0] word;
    logic        rd;
    logic        stop;
    logic [7:0]  data;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{11'h0A5, 1'b0, 1'b0, 8'hA5},
    '{11'h13C, 1'b1, 1'b0, 8'h00},
    '{11'h2FF, 1'b0, 1'b1, 8'hFF},
    '{11'h35A, 1'b1, 1'b1, 8'h00},
    '{11'h000, 1'b0, 1'b0, 8'h00},
    '{11'h4C3, 1'b0, 1'b0, 8'hC3},
    '{11'h1FF, 1'b1, 1'b0, 8'h00},
    '{11'h281, 1'b0, 1'b1, 8'h81}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_cmd(input logic [10:0] w);
    cmd_wr_en = 1'b1; cmd_wr_word = w;
    tick();
    cmd_wr_en = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    eng_rx_valid = 1'b1; eng_rx_data = b;
    tick();
    eng_rx_valid = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual hang expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // Reset state
    chk("R2", "tx_level after reset", 32'(tx_level), 0);
    chk("R2", "rx_level after reset", 32'(rx_level), 0);
    chk("R5", "tx_need_data after reset", 32'(tx_need_data), 1);
    chk("R4", "rx_has_data after reset", 32'(rx_has_data), 0);
    chk("R10", "eng_cmd_valid after reset", 32'(eng_cmd_valid), 0);

    // Table walk: fill the command queue, then drain it through the engine side.
    for (int i = 0; i < 8; i++) begin
      push_cmd(TBL[i].word);
      chk("R2", "tx_level while filling", 32'(tx_level), 32'(i + 1));
      chk("R5", "tx_need_data while filling", 32'(tx_need_data),
          32'((i + 1) <= (DEPTH - 1)));
    end
    push_cmd(11'h055);
    chk("R7", "tx_over after write to full", 32'(tx_over), 1);
    chk("R7", "tx_level after dropped write", 32'(tx_level), 8);
    tick();
    chk("R7", "tx_over is one pulse", 32'(tx_over), 0);
    for (int i = 0; i < 8; i++) begin
      chk("R10", "eng_cmd_valid with entries", 32'(eng_cmd_valid), 1);
      chk("R1", "eng_cmd_is_read", 32'(eng_cmd_is_read), 32'(TBL[i].rd));
      chk("R1", "eng_cmd_stop", 32'(eng_cmd_stop), 32'(TBL[i].stop));
      chk("R3", "eng_cmd_data order", 32'(eng_cmd_data), 32'(TBL[i].data));
      eng_cmd_ready = 1'b1;
      tick();
      eng_cmd_ready = 1'b0;
      chk("R2", "tx_level while draining", 32'(tx_level), 32'(7 - i));
    end
    chk("R7", "dropped word never surfaces", 32'(eng_cmd_valid), 0);

    // Ready with an empty queue does nothing.
    eng_cmd_ready = 1'b1;
    tick();
    eng_cmd_ready = 1'b0;
    chk("R10", "ready on empty keeps level", 32'(tx_level), 0);
    chk("R10", "ready on empty keeps valid low", 32'(eng_cmd_valid), 0);

    // Simultaneous push and pop.
    push_cmd(11'h011);
    cmd_wr_en = 1'b1; cmd_wr_word = 11'h022; eng_cmd_ready = 1'b1;
    tick();
    cmd_wr_en = 1'b0; eng_cmd_ready = 1'b0;
    chk("R2", "push+pop keeps level", 32'(tx_level), 1);
    chk("R3", "head after push+pop", 32'(eng_cmd_data), 32'h22);
    eng_cmd_ready = 1'b1;
    tick();
    eng_cmd_ready = 1'b0;

    // Receive path with threshold 0.
    push_rx(8'h30);
    chk("R2", "rx_level after one byte", 32'(rx_level), 1);
    chk("R4", "rx_has_data at threshold 0", 32'(rx_has_data), 1);
    for (int i = 1; i < 8; i++) push_rx(8'(8'h30 + i));
    push_rx(8'hEE);
    chk("R8", "rx_over after push to full", 32'(rx_over), 1);
    chk("R8", "rx_level after dropped byte", 32'(rx_level), 8);
    for (int i = 0; i < 8; i++) begin
      rx_rd_en = 1'b1;
      tick();
      rx_rd_en = 1'b0;
      chk("R9", "rx_rd_data value and zero upper bits", 32'(rx_rd_data),
          32'(8'h30 + i));
      chk("R3", "rx_level while reading", 32'(rx_level), 32'(7 - i));
    end
    chk("R4", "rx_has_data when empty", 32'(rx_has_data), 0);
    rx_rd_en = 1'b1;
    tick();
    rx_rd_en = 1'b0;
    chk("R8", "rx_under on empty read", 32'(rx_under), 1);
    chk("R8", "rx_rd_data held on underflow", 32'(rx_rd_data), 32'h37);

    // Receive threshold of 3.
    rx_thresh = LW'(3);
    tick();
    for (int i = 0; i < 3; i++) push_rx(8'(8'h50 + i));
    chk("R4", "rx_has_data at level 3 thresh 3", 32'(rx_has_data), 0);
    push_rx(8'h53);
    chk("R4", "rx_has_data at level 4 thresh 3", 32'(rx_has_data), 1);

    // Transmit threshold of 2.
    tx_thresh = LW'(2);
    tick();
    push_cmd(11'h101);
    push_cmd(11'h002);
    chk("R5", "tx_need_data at level 2 thresh 2", 32'(tx_need_data), 1);
    push_cmd(11'h203);
    chk("R5", "tx_need_data at level 3 thresh 2", 32'(tx_need_data), 0);

    // Abort with concurrent requests.
    eng_abort = 1'b1; cmd_wr_en = 1'b1; cmd_wr_word = 11'h0AA;
    eng_rx_valid = 1'b1; eng_rx_data = 8'hBB;
    tick();
    eng_abort = 1'b0; cmd_wr_en = 1'b0; eng_rx_valid = 1'b0;
    chk("R6", "tx_level after abort", 32'(tx_level), 0);
    chk("R6", "rx_level after abort", 32'(rx_level), 0);
    chk("R6", "eng_cmd_valid after abort", 32'(eng_cmd_valid), 0);
    chk("R6", "tx_need_data after abort", 32'(tx_need_data), 1);
    chk("R6", "rx_has_data after abort", 32'(rx_has_data), 0);
    chk("R6", "no error pulse on abort", 32'({tx_over, rx_over, rx_under}), 0);
    rx_rd_en = 1'b1;
    tick();
    rx_rd_en = 1'b0;
    chk("R6", "read after abort underflows", 32'(rx_under), 1);

    tick();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule